// File: doc/BRIEF.md
# Eight-Channel Interleaved Second-Order IIR Filter

This block runs one second-order recursive filter over eight independent sample streams. A single set of five multipliers and one adder tree serves every channel in turn. Samples arrive one per accepted clock, in cyclic channel order 0, 1, …, 7, 0, …, each tagged with its channel number. Every filtered sample leaves one clock later, tagged with the same number. At 48 kHz per channel the array runs at 384 kHz.

Each unit delay of the single-channel filter is built as a shift chain of eight registers. A value written for channel k comes back to the arithmetic exactly eight accepted samples later, which is when channel k is served again. No state memory and no state multiplexers are needed. The chains advance only when a sample is accepted. A synchronous clear empties every chain. The coefficients are parameters in signed Q2.14 format and are shared by all channels.

Top module: `iir8ch`

## Requirements
- R1: After reset, out_valid is 0 and out_y is 0.
- R2: out_valid and out_ch equal in_valid and in_ch of the previous clock, so the latency is one clock.
- R3: For each channel the output is y[n] = sat((B0·x[n] + B1·x[n-1] + B2·x[n-2] − A1·y[n-1] − A2·y[n-2]) >>> 14). Here >>> 14 is an arithmetic right shift, which rounds toward minus infinity. The past y values are the saturated outputs of that channel.
- R4: The result saturates to 32767 when it is above that value and to −32768 when it is below that value.
- R5: An impulse driven on channel k, with zero on all other channels, gives the single-channel impulse response on channel k and zero on every other channel.
- R6: A clock with in_valid low leaves all channel state and out_y unchanged. The filter then continues as if that clock had not occurred.
- R7: A clear pulse zeroes out_y, drops out_valid on the next clock, and empties the state of all eight channels. Clear takes priority over a sample presented in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of all channel state |
| in_valid | input | 1 | Input sample is present |
| in_ch | input | 3 | Channel number of the input sample |
| in_x | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample is present |
| out_ch | output | 3 | Channel number of the output sample |
| out_y | output | 16 | Signed filtered sample |

## Verification
Each channel is driven in turn with an isolated impulse. This shows whether the delay chains keep channels apart or let state leak into a neighbour slot one position off. Pseudo-random streams on all eight channels at once check the full difference equation against an arithmetic model in the bench. Large constant inputs of both signs drive the recursion into both saturation limits. Streams with idle clocks and a clear in mid-stream show whether the chains stall correctly and whether every slot is emptied.

// File: rtl/iir8ch.sv
module iir8ch #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int FRAC = 14,
  parameter int NCH  = 8,
  parameter logic signed [CW-1:0] B0 = 16'sd4096,
  parameter logic signed [CW-1:0] B1 = 16'sd8192,
  parameter logic signed [CW-1:0] B2 = 16'sd4096,
  parameter logic signed [CW-1:0] A1 = -16'sd13107,
  parameter logic signed [CW-1:0] A2 = 16'sd4915
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       in_valid,
  input  logic [$clog2(NCH)-1:0]     in_ch,
  input  logic signed [DW-1:0]       in_x,
  output logic                       out_valid,
  output logic [$clog2(NCH)-1:0]     out_ch,
  output logic signed [DW-1:0]       out_y
);
  localparam int CHW  = $clog2(NCH);
  localparam int ACCW = DW + CW + 3;
  localparam logic signed [ACCW-1:0] HI = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] LO = ~HI;

  logic signed [DW-1:0] xd1 [NCH];
  logic signed [DW-1:0] xd2 [NCH];
  logic signed [DW-1:0] yd1 [NCH];
  logic signed [DW-1:0] yd2 [NCH];

  logic signed [ACCW-1:0] acc, shf;
  logic signed [DW-1:0]   ysat;

  assign acc = ACCW'(in_x)         * ACCW'(B0)
             + ACCW'(xd1[NCH-1])   * ACCW'(B1)
             + ACCW'(xd2[NCH-1])   * ACCW'(B2)
             - ACCW'(yd1[NCH-1])   * ACCW'(A1)
             - ACCW'(yd2[NCH-1])   * ACCW'(A2);
  assign shf  = acc >>> FRAC;
  assign ysat = (shf > HI) ? HI[DW-1:0] : (shf < LO) ? LO[DW-1:0] : shf[DW-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NCH; i++) begin
        xd1[i] <= '0; xd2[i] <= '0; yd1[i] <= '0; yd2[i] <= '0;
      end
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_y     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        xd1[0] <= in_x;
        xd2[0] <= xd1[NCH-1];
        yd1[0] <= ysat;
        yd2[0] <= yd1[NCH-1];
        for (int i = 1; i < NCH; i++) begin
          xd1[i] <= xd1[i-1]; xd2[i] <= xd2[i-1];
          yd1[i] <= yd1[i-1]; yd2[i] <= yd2[i-1];
        end
        out_ch <= in_ch;
        out_y  <= ysat;
      end
    end
  end

  assert_tag_follows_R2: assert property (@(posedge clk) disable iff (rst || clr)
    in_valid |=> out_valid && out_ch == $past(in_ch));
  assert_idle_no_valid_R2: assert property (@(posedge clk) disable iff (rst || clr)
    !in_valid |=> !out_valid);
  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clr) |=> $stable(out_y) && $stable(out_ch));
  assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> out_y == '0 && !out_valid);
endmodule

// File: tb/iir8ch_tb_top.sv
module iir8ch_tb_top;
  logic clk = 1'b0, rst = 1'b1, clr = 1'b0, in_valid = 1'b0;
  logic [2:0] in_ch = '0;
  logic signed [15:0] in_x = '0;
  logic out_valid;
  logic [2:0] out_ch;
  logic signed [15:0] out_y;

  iir8ch dut_i (.clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_ch(in_ch),
                .in_x(in_x), .out_valid(out_valid), .out_ch(out_ch), .out_y(out_y));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  longint mx1[8], mx2[8], my1[8], my2[8];
  logic [2:0] rc = '0;
  logic [31:0] seed = 32'h1234_5678;
  int sat_hi = 0, sat_lo = 0;

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) begin mx1[i] = 0; mx2[i] = 0; my1[i] = 0; my2[i] = 0; end
    rc = '0;
  endtask

  function automatic longint model(int ch, longint x);
    longint acc, y;
    acc = 4096*x + 8192*mx1[ch] + 4096*mx2[ch] + 13107*my1[ch] - 4915*my2[ch];
    y = acc >>> 14;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    mx2[ch] = mx1[ch]; mx1[ch] = x; my2[ch] = my1[ch]; my1[ch] = y;
    return y;
  endfunction

  task automatic send(longint x, string req);
    longint e;
    @(negedge clk);
    in_valid = 1'b1; in_ch = rc; in_x = 16'(x);
    e = model(int'(rc), x);
    @(posedge clk); #1;
    check("R2", longint'(out_valid), 1);
    check("R2", longint'(out_ch), longint'(rc));
    check(req, longint'(out_y), e);
    if (e == 32767) sat_hi++;
    if (e == -32768) sat_lo++;
    rc = rc + 3'd1;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic idle();
    logic signed [15:0] prev;
    @(negedge clk);
    prev = out_y;
    in_valid = 1'b0; in_x = 16'sh7fff;
    @(posedge clk); #1;
    check("R2", longint'(out_valid), 0);
    check("R6", longint'(out_y), longint'(prev));
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1; in_valid = 1'b1; in_x = 16'sd20000;
    @(posedge clk); #1;
    check("R7", longint'(out_y), 0);
    check("R7", longint'(out_valid), 0);
    @(negedge clk); clr = 1'b0; in_valid = 1'b0;
    model_clear();
  endtask

  function automatic longint rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return longint'($signed(seed[23:8]) >>> 1);
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    check("R1", longint'(out_valid), 0);
    check("R1", longint'(out_y), 0);
    @(negedge clk); rst = 1'b0;

    // R5 / R3: impulse on each channel alone
    for (int k = 0; k < 8; k++) begin
      do_clear();
      for (int n = 0; n < 8*16; n++)
        send((n == k) ? 64'sd16384 : 64'sd0, "R5");
      check("R5", longint'(mx1[k] == 0 && my1[k] != 0 || my1[k] == 0), 1);
    end

    // R3: random streams on all channels
    do_clear();
    for (int n = 0; n < 8*60; n++) send(rnd(), "R3");

    // R6: idle clocks interleaved with samples
    for (int n = 0; n < 8*30; n++) begin
      send(rnd(), "R6");
      if (n % 3 == 1) idle();
      if (n % 7 == 4) begin idle(); idle(); end
    end

    // R7: clear in mid-stream, then a fresh impulse on channel 3
    do_clear();
    for (int n = 0; n < 8*12; n++) send((n == 3) ? 64'sd10000 : 64'sd0, "R7");

    // R4: drive both saturation limits
    do_clear();
    for (int n = 0; n < 8*25; n++) send(64'sd30000, "R4");
    check("R4", longint'(out_y), 32767);
    for (int n = 0; n < 8*25; n++) send(-64'sd30000, "R4");
    check("R4", longint'(out_y), -32768);
    check("R4", longint'(sat_hi > 0 && sat_lo > 0), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule